// File: doc/BRIEF.md
# Linked-Descriptor DMA Channel

This block is one DMA channel that follows a chain of command descriptors stored in system memory. It moves bytes between memory and a single peripheral, in either direction. Each descriptor can also hand a short run of 32-bit control words to the peripheral before its data phase begins. Software writes the address of the first descriptor and then adds to a semaphore counter. The channel fetches descriptors only while that counter is nonzero. A descriptor can ask for the counter to be decremented when it retires, so software can queue work one descriptor at a time or in bulk.

The memory side is a simple word-wide master that completes a beat in any cycle where request and ready are both high. An error response on that port stops the channel until reset. The peripheral side has a 32-bit control-word output, a byte output stream, a byte input stream and an end-of-command input. Each of these uses valid/ready handshakes. Interrupt flags for completion and for error are masked by a shared enable and cleared together by one pulse.

Top module: `desc_dma_chan`

## Requirements
- R1: A descriptor at pointer P is three words, read in this order: next-descriptor address at P, command word at P+4, buffer address at P+8. Buffer address bits [1:0] are ignored.
- R2: Command bits [1:0] select the operation. 1 moves bytes from the peripheral input stream into memory. 2 moves bytes from memory to the peripheral output stream. 0 and 3 move no data.
- R3: Command bits [15:12] give N, a count from 0 to 15. Before any data moves, the channel reads N control words from P+12+4i and presents them in order on the control-word output.
- R4: Command bits [31:16] give the byte count, and 0 means 65536. Byte k of a word lies in bits [8k+7:8k]. When data goes to memory, one write is issued per 4 bytes plus one for a final partial word, and the unused upper bytes of that partial word are zero.
- R5: Command bit 2 (chain) makes the channel take the fetched next address as its new pointer when the descriptor retires, and continue while the semaphore is nonzero. With chain clear, the channel stays idle until the next nonzero semaphore increment.
- R6: A semaphore increment adds its amount, saturating at the maximum. Command bit 6 decrements the semaphore by one at retirement. No descriptor fetch starts while the value is zero. `sema_val` shows the current value.
- R7: Command bit 3 sets the completion flag at retirement. `irq_done` is that flag ANDed with `irq_en`, and the flag is kept while masked.
- R8: With command bit 7 set, a descriptor does not retire until `perif_endcmd` is high.
- R9: While `freeze` is high, the channel raises no memory request, no peripheral valid and no peripheral ready, and its state does not advance.
- R10: An error response on a memory beat sets the error flag. The error shows on `err_stat` and, when enabled, on `irq_err`. The channel then raises no further memory request until reset.
- R11: An `irq_clr` pulse clears the completion and error flags together.
- R12: After reset, the semaphore and both flags are zero and no memory request or peripheral handshake is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nxt_ptr_we | input | 1 | Write strobe for the descriptor pointer |
| nxt_ptr_wdata | input | 32 | New descriptor pointer |
| sema_inc_we | input | 1 | Semaphore increment strobe |
| sema_inc_amt | input | SEMA_W | Amount added to the semaphore |
| sema_val | output | SEMA_W | Current semaphore value |
| freeze | input | 1 | Stall the channel |
| irq_en | input | 1 | Interrupt output enable |
| irq_clr | input | 1 | Clear completion and error flags |
| err_stat | output | 1 | Raw error flag |
| irq_done | output | 1 | Masked completion interrupt |
| irq_err | output | 1 | Masked error interrupt |
| mem_req | output | 1 | Memory request |
| mem_addr | output | 32 | Memory byte address (word aligned) |
| mem_we | output | 1 | Memory write enable |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data |
| mem_ready | input | 1 | Memory beat completes |
| mem_err | input | 1 | Error response, valid with mem_ready |
| pio_valid | output | 1 | Control word valid |
| pio_data | output | 32 | Control word to peripheral |
| pio_ready | input | 1 | Peripheral accepts control word |
| tx_valid | output | 1 | Byte to peripheral valid |
| tx_data | output | 8 | Byte to peripheral |
| tx_ready | input | 1 | Peripheral accepts byte |
| rx_valid | input | 1 | Byte from peripheral valid |
| rx_data | input | 8 | Byte from peripheral |
| rx_ready | output | 1 | Channel accepts byte |
| perif_endcmd | input | 1 | Peripheral end-of-command |

## Verification
Most wrong internal states show up at the memory port within a few cycles. A mis-advanced fetch index sends the command word to the wrong address on the next beat, and a bad byte lane corrupts the very next transmitted byte or written word. A wrong semaphore value shows directly on `sema_val` one cycle after the faulty update. It also shows as a chained descriptor that starts when it should not, or never starts. Errors in the retirement bookkeeping (chain pointer, completion flag, end-of-command wait) show only when a descriptor finishes. The bench therefore runs each pattern until `irq_done` rises, and then checks the bytes, words and counter values that retirement should have left.

// File: rtl/dma_pkg.sv
package dma_pkg;

  localparam int WORD_W   = 32;
  localparam int COUNT_W  = 17;
  localparam int PIO_W    = 4;
  localparam int DESC_HDR = 3;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_WRITE = 2'd1,
    OP_READ  = 2'd2,
    OP_SENSE = 2'd3
  } op_e;

  typedef enum logic [3:0] {
    ST_IDLE, ST_FETCH, ST_PIO_RD, ST_PIO_TX, ST_RD_MEM,
    ST_TX, ST_RX, ST_WR_MEM, ST_END, ST_HALT
  } st_e;

  typedef struct packed {
    op_e                op;
    logic               chain;
    logic               irq;
    logic               sema;
    logic               wait_end;
    logic [PIO_W-1:0]   pio_n;
    logic [COUNT_W-1:0] bytes;
  } cmd_t;

  // zero in the count field stands for the full 64 KiB
  function automatic logic [COUNT_W-1:0] byte_total(input logic [15:0] f);
    return (f == 16'd0) ? 17'h10000 : {1'b0, f};
  endfunction

  function automatic cmd_t cmd_decode(input logic [WORD_W-1:0] w);
    cmd_t c;
    c.op       = op_e'(w[1:0]);
    c.chain    = w[2];
    c.irq      = w[3];
    c.sema     = w[6];
    c.wait_end = w[7];
    c.pio_n    = w[15:12];
    c.bytes    = byte_total(w[31:16]);
    return c;
  endfunction

  function automatic logic [WORD_W-1:0] word_addr(input logic [WORD_W-1:0] base,
                                                  input logic [4:0] idx);
    return base + {25'd0, idx, 2'b00};
  endfunction

  function automatic logic [7:0] lane_get(input logic [WORD_W-1:0] w, input logic [1:0] l);
    return w[{l, 3'b000} +: 8];
  endfunction

  // lane 0 starts a fresh word so unused upper bytes stay zero
  function automatic logic [WORD_W-1:0] lane_put(input logic [WORD_W-1:0] w,
                                                 input logic [1:0] l, input logic [7:0] b);
    logic [WORD_W-1:0] r;
    r = (l == 2'd0) ? '0 : w;
    r[{l, 3'b000} +: 8] = b;
    return r;
  endfunction

  function automatic st_e data_state(input op_e op);
    case (op)
      OP_READ:  return ST_RD_MEM;
      OP_WRITE: return ST_RX;
      default:  return ST_END;
    endcase
  endfunction

endpackage

// File: rtl/dma_sema.sv
module dma_sema #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc_we,
  input  logic [W-1:0] inc_amt,
  input  logic         dec,
  output logic [W-1:0] count,
  output logic         nonzero
);
  logic [W:0] sum;
  logic [W-1:0] cnt_d;

  always_comb begin
    sum = {1'b0, count} + (inc_we ? {1'b0, inc_amt} : '0);
    if (dec && sum != '0) sum = sum - 1'b1;
    cnt_d = sum[W] ? '1 : sum[W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) count <= '0;
    else        count <= cnt_d;

  assign nonzero = (count != '0);
endmodule

// File: rtl/dma_irq.sv
module dma_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic set_done,
  input  logic set_err,
  input  logic clr,
  input  logic en,
  output logic err_flag,
  output logic irq_done,
  output logic irq_err
);
  logic done_flag;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      done_flag <= 1'b0;
      err_flag  <= 1'b0;
    end else begin
      done_flag <= set_done | (done_flag & ~clr);
      err_flag  <= set_err  | (err_flag  & ~clr);
    end

  assign irq_done = done_flag & en;
  assign irq_err  = err_flag & en;
endmodule

// File: rtl/dma_seq.sv
module dma_seq
  import dma_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              freeze,
  input  logic              sema_nz,
  input  logic              arm,
  input  logic              nxt_we,
  input  logic [WORD_W-1:0] nxt_wdata,
  output logic              mem_req,
  output logic [WORD_W-1:0] mem_addr,
  output logic              mem_we,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic [WORD_W-1:0] mem_rdata,
  input  logic              mem_ready,
  input  logic              mem_err,
  output logic              pio_valid,
  output logic [WORD_W-1:0] pio_data,
  input  logic              pio_ready,
  output logic              tx_valid,
  output logic [7:0]        tx_data,
  input  logic              tx_ready,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  output logic              rx_ready,
  input  logic              perif_endcmd,
  output logic              ev_fetch,
  output logic              ev_retire,
  output logic              ev_done,
  output logic              ev_sema_dec,
  output logic              ev_err,
  output logic              cmd_wait,
  output logic              halted
);
  st_e                state;
  cmd_t               cmd_q;
  logic [PIO_W-1:0]   idx;
  logic [1:0]         lane;
  logic [COUNT_W-1:0] remain;
  logic [WORD_W-1:0]  nxt_ptr, cur_ptr, desc_next, bufp, word_buf;
  logic               armed;

  logic mem_state, mem_ack, adv, can_retire, pio_last;

  assign adv       = ~freeze;
  assign mem_state = (state == ST_FETCH) || (state == ST_PIO_RD) ||
                     (state == ST_RD_MEM) || (state == ST_WR_MEM);
  assign mem_req   = mem_state && adv;
  assign mem_ack   = mem_req && mem_ready && !mem_err;
  assign ev_err    = mem_req && mem_ready && mem_err;
  assign mem_we    = (state == ST_WR_MEM);
  assign mem_wdata = word_buf;

  always_comb begin
    case (state)
      ST_FETCH:  mem_addr = word_addr(cur_ptr, {1'b0, idx});
      ST_PIO_RD: mem_addr = word_addr(cur_ptr, {1'b0, idx} + 5'(DESC_HDR));
      default:   mem_addr = bufp;
    endcase
  end

  assign pio_valid = (state == ST_PIO_TX) && adv;
  assign pio_data  = word_buf;
  assign tx_valid  = (state == ST_TX) && adv;
  assign tx_data   = lane_get(word_buf, lane);
  assign rx_ready  = (state == ST_RX) && adv;
  assign pio_last  = ({1'b0, idx} + 5'd1) == {1'b0, cmd_q.pio_n};

  assign ev_fetch    = (state == ST_IDLE) && adv && armed && sema_nz;
  assign can_retire  = !cmd_q.wait_end || perif_endcmd;
  assign ev_retire   = (state == ST_END) && adv && can_retire;
  assign ev_done     = ev_retire && cmd_q.irq;
  assign ev_sema_dec = ev_retire && cmd_q.sema;
  assign cmd_wait    = cmd_q.wait_end;
  assign halted      = (state == ST_HALT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cmd_q     <= '0;
      idx       <= '0;
      lane      <= '0;
      remain    <= '0;
      nxt_ptr   <= '0;
      cur_ptr   <= '0;
      desc_next <= '0;
      bufp      <= '0;
      word_buf  <= '0;
      armed     <= 1'b0;
    end else begin
      if (nxt_we) nxt_ptr <= nxt_wdata;
      if (arm)    armed   <= 1'b1;
      if (ev_err) state   <= ST_HALT;
      else if (adv) begin
        case (state)
          ST_IDLE: if (armed && sema_nz) begin
            cur_ptr <= nxt_ptr;
            idx     <= '0;
            state   <= ST_FETCH;
          end
          ST_FETCH: if (mem_ack) begin
            case (idx[1:0])
              2'd0:    desc_next <= mem_rdata;
              2'd1:    cmd_q     <= cmd_decode(mem_rdata);
              default: bufp      <= {mem_rdata[WORD_W-1:2], 2'b00};
            endcase
            if (idx == 4'd2) begin
              idx    <= '0;
              lane   <= '0;
              remain <= cmd_q.bytes;
              state  <= (cmd_q.pio_n != '0) ? ST_PIO_RD : data_state(cmd_q.op);
            end else idx <= idx + 1'b1;
          end
          ST_PIO_RD: if (mem_ack) begin
            word_buf <= mem_rdata;
            state    <= ST_PIO_TX;
          end
          ST_PIO_TX: if (pio_ready) begin
            idx   <= idx + 1'b1;
            state <= pio_last ? data_state(cmd_q.op) : ST_PIO_RD;
          end
          ST_RD_MEM: if (mem_ack) begin
            word_buf <= mem_rdata;
            lane     <= '0;
            state    <= ST_TX;
          end
          ST_TX: if (tx_ready) begin
            remain <= remain - 1'b1;
            lane   <= lane + 1'b1;
            if (remain == 17'd1) state <= ST_END;
            else if (lane == 2'd3) begin
              bufp  <= bufp + 32'd4;
              state <= ST_RD_MEM;
            end
          end
          ST_RX: if (rx_valid) begin
            word_buf <= lane_put(word_buf, lane, rx_data);
            remain   <= remain - 1'b1;
            lane     <= lane + 1'b1;
            if (lane == 2'd3 || remain == 17'd1) state <= ST_WR_MEM;
          end
          ST_WR_MEM: if (mem_ack) begin
            bufp  <= bufp + 32'd4;
            lane  <= '0;
            state <= (remain == '0) ? ST_END : ST_RX;
          end
          ST_END: if (can_retire) begin
            if (cmd_q.chain) nxt_ptr <= desc_next;
            else if (!arm)   armed   <= 1'b0;
            state <= ST_IDLE;
          end
          default: state <= ST_HALT;
        endcase
      end
    end
  end
endmodule

// File: rtl/desc_dma_chan.sv
module desc_dma_chan
  import dma_pkg::*;
#(
  parameter int SEMA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              nxt_ptr_we,
  input  logic [31:0]       nxt_ptr_wdata,
  input  logic              sema_inc_we,
  input  logic [SEMA_W-1:0] sema_inc_amt,
  output logic [SEMA_W-1:0] sema_val,
  input  logic              freeze,
  input  logic              irq_en,
  input  logic              irq_clr,
  output logic              err_stat,
  output logic              irq_done,
  output logic              irq_err,
  output logic              mem_req,
  output logic [31:0]       mem_addr,
  output logic              mem_we,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata,
  input  logic              mem_ready,
  input  logic              mem_err,
  output logic              pio_valid,
  output logic [31:0]       pio_data,
  input  logic              pio_ready,
  output logic              tx_valid,
  output logic [7:0]        tx_data,
  input  logic              tx_ready,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  output logic              rx_ready,
  input  logic              perif_endcmd
);
  logic sema_nz, arm;
  logic ev_fetch, ev_retire, ev_done, ev_sema_dec, ev_err, cmd_wait, halted;

  assign arm = sema_inc_we && (sema_inc_amt != '0);

  dma_sema #(.W(SEMA_W)) u_sema (
    .clk(clk), .rst_n(rst_n), .inc_we(sema_inc_we), .inc_amt(sema_inc_amt),
    .dec(ev_sema_dec), .count(sema_val), .nonzero(sema_nz)
  );

  dma_irq u_irq (
    .clk(clk), .rst_n(rst_n), .set_done(ev_done), .set_err(ev_err),
    .clr(irq_clr), .en(irq_en), .err_flag(err_stat),
    .irq_done(irq_done), .irq_err(irq_err)
  );

  dma_seq u_seq (
    .clk(clk), .rst_n(rst_n), .freeze(freeze), .sema_nz(sema_nz), .arm(arm),
    .nxt_we(nxt_ptr_we), .nxt_wdata(nxt_ptr_wdata),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ready(mem_ready), .mem_err(mem_err),
    .pio_valid(pio_valid), .pio_data(pio_data), .pio_ready(pio_ready),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
    .perif_endcmd(perif_endcmd),
    .ev_fetch(ev_fetch), .ev_retire(ev_retire), .ev_done(ev_done),
    .ev_sema_dec(ev_sema_dec), .ev_err(ev_err), .cmd_wait(cmd_wait), .halted(halted)
  );
endmodule

// File: rtl/dma_chan_chk.sv
module dma_chan_chk #(
  parameter int SEMA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              freeze,
  input logic              mem_req,
  input logic              tx_valid,
  input logic              rx_ready,
  input logic              pio_valid,
  input logic              halted,
  input logic              ev_fetch,
  input logic              ev_retire,
  input logic              ev_sema_dec,
  input logic              ev_done,
  input logic              ev_err,
  input logic              cmd_wait,
  input logic              perif_endcmd,
  input logic              sema_inc_we,
  input logic [SEMA_W-1:0] sema_val,
  input logic              irq_clr,
  input logic              irq_done,
  input logic              irq_err
);
  AST_FREEZE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    freeze |-> !mem_req && !tx_valid && !rx_ready && !pio_valid); // R9

  AST_HALT_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !mem_req); // R10

  AST_ERR_TO_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    ev_err |=> halted); // R10

  AST_FETCH_NEEDS_SEMA: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fetch |-> sema_val != '0); // R6

  AST_SEMA_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    ev_sema_dec && !sema_inc_we |=> sema_val == $past(sema_val) - 1'b1); // R6

  AST_WAIT_END: assert property (@(posedge clk) disable iff (!rst_n)
    ev_retire && cmd_wait |-> perif_endcmd); // R8

  AST_CLEAR_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    irq_clr && !ev_done && !ev_err |=> !irq_done && !irq_err); // R11

  AST_ONE_STREAM: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({tx_valid, rx_ready, pio_valid})); // R2
endmodule

bind desc_dma_chan dma_chan_chk #(.SEMA_W(SEMA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .freeze(freeze), .mem_req(mem_req),
  .tx_valid(tx_valid), .rx_ready(rx_ready), .pio_valid(pio_valid),
  .halted(halted), .ev_fetch(ev_fetch), .ev_retire(ev_retire),
  .ev_sema_dec(ev_sema_dec), .ev_done(ev_done), .ev_err(ev_err),
  .cmd_wait(cmd_wait), .perif_endcmd(perif_endcmd), .sema_inc_we(sema_inc_we),
  .sema_val(sema_val), .irq_clr(irq_clr), .irq_done(irq_done), .irq_err(irq_err)
);

// File: tb/sim_desc_dma_chan.sv
`timescale 1ns/1ps
module sim_desc_dma_chan;
  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        nxt_ptr_we = 0, sema_inc_we = 0, freeze = 0, irq_en = 1, irq_clr = 0;
  logic [31:0] nxt_ptr_wdata = 0;
  logic [7:0]  sema_inc_amt = 0, sema_val;
  logic        err_stat, irq_done, irq_err;
  logic        mem_req, mem_we, mem_err;
  logic [31:0] mem_addr, mem_wdata, mem_rdata, pio_data;
  logic        pio_valid, tx_valid, rx_ready;
  logic [7:0]  tx_data, rx_data;
  logic        perif_endcmd = 0;

  logic [31:0] mem [0:255];
  logic [31:0] pio_log [0:15];
  logic [7:0]  tx_log [0:63];
  int tx_n = 0, pio_n = 0, rx_n = 0, wr_n = 0, req_n = 0;
  logic [31:0] last_wr = 0;
  int checks = 0, fails = 0;

  assign mem_rdata = (mem_addr < 32'd1024) ? mem[mem_addr[9:2]] : 32'h0;
  assign mem_err   = mem_req && (mem_addr[31:28] == 4'hE);
  assign rx_data   = 8'(rx_n + 5);

  desc_dma_chan u0 (
    .clk(clk), .rst_n(rst_n), .nxt_ptr_we(nxt_ptr_we), .nxt_ptr_wdata(nxt_ptr_wdata),
    .sema_inc_we(sema_inc_we), .sema_inc_amt(sema_inc_amt), .sema_val(sema_val),
    .freeze(freeze), .irq_en(irq_en), .irq_clr(irq_clr), .err_stat(err_stat),
    .irq_done(irq_done), .irq_err(irq_err), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(1'b1),
    .mem_err(mem_err), .pio_valid(pio_valid), .pio_data(pio_data), .pio_ready(1'b1),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(1'b1), .rx_valid(1'b1),
    .rx_data(rx_data), .rx_ready(rx_ready), .perif_endcmd(perif_endcmd)
  );

  // memory and peripheral models
  always @(posedge clk) begin
    if (mem_req) req_n <= req_n + 1;
    if (mem_req && !mem_err && mem_we) begin
      wr_n    <= wr_n + 1;
      last_wr <= mem_addr;
      if (mem_addr < 32'd1024) mem[mem_addr[9:2]] <= mem_wdata;
    end
    if (tx_valid) begin
      if (tx_n < 64) tx_log[tx_n] <= tx_data;
      tx_n <= tx_n + 1;
    end
    if (pio_valid) begin
      if (pio_n < 16) pio_log[pio_n] <= pio_data;
      pio_n <= pio_n + 1;
    end
    if (rx_ready) rx_n <= rx_n + 1;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_cmd(input logic [1:0] op, input logic [3:0] pio,
      input logic [15:0] cnt, input bit chain, input bit irq, input bit sema, input bit wt);
    return {cnt, pio, 4'b0, wt, sema, 2'b00, irq, chain, op};
  endfunction

  function automatic logic [7:0] rd_pat(input int j);
    return 8'(j * 7 + 3);
  endfunction

  task automatic clear_logs();
    @(negedge clk);
    tx_n = 0; pio_n = 0; rx_n = 0; wr_n = 0; req_n = 0;
  endtask

  task automatic do_reset();
    rst_n = 0;
    for (int i = 0; i < 256; i++) mem[i] = 32'h0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    clear_logs();
  endtask

  task automatic set_ptr(input logic [31:0] p);
    @(negedge clk); nxt_ptr_we = 1; nxt_ptr_wdata = p;
    @(negedge clk); nxt_ptr_we = 0;
  endtask

  task automatic inc_sema(input logic [7:0] a);
    @(negedge clk); sema_inc_we = 1; sema_inc_amt = a;
    @(negedge clk); sema_inc_we = 0;
  endtask

  task automatic pulse_clr();
    @(negedge clk); irq_clr = 1;
    @(negedge clk); irq_clr = 0;
  endtask

  task automatic wait_done(input int max);
    for (int i = 0; i < max; i++) begin
      @(negedge clk);
      if (irq_done) break;
    end
  endtask

  task automatic fill_read_buf(input int word0);
    for (int k = 0; k < 8; k++)
      for (int b = 0; b < 4; b++) mem[word0 + k][8*b +: 8] = rd_pat(4 * k + b);
  endtask

  // vector: [22:21] op, [20:17] pio count, [16:1] byte count, [0] semaphore flag
  localparam logic [22:0] VEC [6] = '{
    {2'd0, 4'd0, 16'd0, 1'b1},
    {2'd2, 4'd0, 16'd5, 1'b0},
    {2'd2, 4'd2, 16'd8, 1'b1},
    {2'd1, 4'd0, 16'd6, 1'b0},
    {2'd1, 4'd3, 16'd4, 1'b1},
    {2'd3, 4'd1, 16'd9, 1'b0}
  };

  initial begin
    repeat (190000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int sema_model;
    do_reset();
    // R12 reset state
    chk(!mem_req && !tx_valid && !rx_ready && !pio_valid, "R12 idle handshakes", {28'd0, mem_req, tx_valid, rx_ready, pio_valid}, 0);
    chk(sema_val == 0 && !err_stat && !irq_done && !irq_err, "R12 counters/flags", {sema_val, 1'b0, err_stat, irq_done, irq_err}, 0);

    // R6 no fetch while semaphore is zero
    set_ptr(32'h0);
    repeat (10) @(negedge clk);
    chk(req_n == 0, "R6 no fetch at zero sema", req_n, 0);

    // vector table walk: R1 R2 R3 R4 R6 R7
    sema_model = 0;
    foreach (VEC[v]) begin
      logic [1:0] op; logic [3:0] pn; logic [15:0] cnt; bit sf; int nw;
      {op, pn, cnt, sf} = VEC[v];
      mem[0] = 32'h0; mem[1] = mk_cmd(op, pn, cnt, 0, 1, sf, 0); mem[2] = 32'h203;
      for (int i = 0; i < 15; i++) mem[3 + i] = 32'hC0DE_0000 + i;
      if (op == 2'd2) fill_read_buf(128);
      else for (int k = 0; k < 8; k++) mem[128 + k] = 32'hDEADBEEF;
      pulse_clr();
      clear_logs();
      set_ptr(32'h0);
      inc_sema(1);
      sema_model = sema_model + 1 - int'(sf);
      wait_done(500);
      chk(irq_done, $sformatf("R7 vector %0d done", v), irq_done, 1);
      chk(pio_n == pn, $sformatf("R3 vector %0d pio count", v), pio_n, pn);
      for (int i = 0; i < pn; i++)
        chk(pio_log[i] == 32'hC0DE_0000 + i, "R3 pio word order", pio_log[i], 32'hC0DE_0000 + i);
      chk(sema_val == 8'(sema_model), $sformatf("R6 vector %0d sema", v), sema_val, sema_model);
      if (op == 2'd2) begin
        chk(tx_n == cnt, "R2 read byte count", tx_n, cnt);
        for (int j = 0; j < cnt; j++)
          chk(tx_log[j] == rd_pat(j), "R4 read byte lane", tx_log[j], rd_pat(j));
      end else chk(tx_n == 0, "R2 no bytes out", tx_n, 0);
      if (op == 2'd1) begin
        nw = (cnt + 3) / 4;
        chk(wr_n == nw, "R4 write beat count", wr_n, nw);
        for (int k = 0; k < nw; k++) begin
          logic [31:0] e;
          e = 0;
          for (int b = 0; b < 4; b++) if (4 * k + b < cnt) e[8*b +: 8] = 8'(4 * k + b + 5);
          chk(mem[128 + k] == e, "R4 write word / zero fill", mem[128 + k], e);
        end
        chk(mem[128 + nw] == 32'hDEADBEEF, "R4 no extra write", mem[128 + nw], 32'hDEADBEEF);
      end else chk(wr_n == 0, "R2 no memory writes", wr_n, 0);
    end

    // R5 chain of two descriptors
    do_reset();
    mem[16] = 32'h80; mem[17] = mk_cmd(2, 0, 3, 1, 0, 1, 0); mem[18] = 32'h200;
    mem[32] = 32'h0;  mem[33] = mk_cmd(2, 0, 2, 0, 1, 1, 0); mem[34] = 32'h240;
    fill_read_buf(128); fill_read_buf(144);
    set_ptr(32'h40); inc_sema(2);
    wait_done(500);
    chk(tx_n == 5, "R5 chained byte total", tx_n, 5);
    chk(tx_log[3] == rd_pat(0), "R5 second buffer used", tx_log[3], rd_pat(0));
    chk(sema_val == 0, "R6 two decrements", sema_val, 0);

    // R6 semaphore gates the chained descriptor
    do_reset();
    mem[16] = 32'h80; mem[17] = mk_cmd(2, 0, 3, 1, 1, 1, 0); mem[18] = 32'h200;
    mem[32] = 32'h0;  mem[33] = mk_cmd(2, 0, 2, 0, 1, 1, 0); mem[34] = 32'h240;
    fill_read_buf(128); fill_read_buf(144);
    set_ptr(32'h40); inc_sema(1);
    wait_done(500);
    pulse_clr();
    repeat (30) @(negedge clk);
    chk(tx_n == 3, "R6 stopped at zero sema", tx_n, 3);
    inc_sema(1);
    wait_done(500);
    chk(tx_n == 5 && irq_done, "R5 resumed from next pointer", tx_n, 5);

    // R8 end-of-command wait
    do_reset();
    mem[1] = mk_cmd(0, 0, 1, 0, 1, 0, 1);
    set_ptr(32'h0); inc_sema(1);
    repeat (30) @(negedge clk);
    chk(!irq_done, "R8 held until end-of-command", irq_done, 0);
    perif_endcmd = 1; @(negedge clk); perif_endcmd = 0;
    @(negedge clk);
    chk(irq_done, "R8 retires on end-of-command", irq_done, 1);

    // R9 freeze
    do_reset();
    mem[1] = mk_cmd(2, 0, 4, 0, 1, 0, 0); mem[2] = 32'h200; fill_read_buf(128);
    freeze = 1;
    set_ptr(32'h0); inc_sema(1);
    repeat (20) @(negedge clk);
    chk(req_n == 0 && tx_n == 0, "R9 frozen", req_n + tx_n, 0);
    freeze = 0;
    wait_done(500);
    chk(tx_n == 4, "R9 resumes after freeze", tx_n, 4);

    // R7 masked completion kept pending
    do_reset();
    irq_en = 0;
    mem[1] = mk_cmd(0, 0, 1, 0, 1, 0, 0);
    set_ptr(32'h0); inc_sema(1);
    repeat (20) @(negedge clk);
    chk(!irq_done, "R7 masked", irq_done, 0);
    irq_en = 1; @(negedge clk);
    chk(irq_done, "R7 flag kept while masked", irq_done, 1);

    // R10 R11 error halts, clear drops both flags
    do_reset();
    set_ptr(32'hE000_0000); inc_sema(1);
    repeat (10) @(negedge clk);
    chk(irq_err && err_stat, "R10 error flagged", {30'd0, irq_err, err_stat}, 3);
    pulse_clr();
    chk(!irq_err && !err_stat && !irq_done, "R11 clear both", {29'd0, irq_err, err_stat, irq_done}, 0);
    clear_logs();
    set_ptr(32'h0); inc_sema(1);
    repeat (20) @(negedge clk);
    chk(req_n == 0, "R10 halted until reset", req_n, 0);

    // R4 zero count means 65536 bytes
    do_reset();
    mem[1] = mk_cmd(1, 0, 0, 0, 1, 0, 0); mem[2] = 32'h10000;
    set_ptr(32'h0); inc_sema(1);
    wait_done(120000);
    chk(wr_n == 16384, "R4 full 64K write beats", wr_n, 16384);
    chk(last_wr == 32'h1FFFC, "R4 last write address", last_wr, 32'h1FFFC);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule